// File: doc/BRIEF.md
# Two-Wire Serial Slave Bus Front End

This block sits between the two-wire serial bus pins of a memory slave and the memory controller behind it. It brings the clock line and the data line into the system clock domain and finds the framing conditions. A frame opens when the data line falls while the clock line is high, and closes when the data line rises while the clock line is high. Between these it shifts bytes in, most significant bit first, with one bit taken on each clock-line rising edge. It returns an acknowledge after the slave address byte and after each write data byte. In a read it shifts bytes supplied by the controller out onto the data line. The block only pulls the data line low or releases it, and it changes that drive only while the bus clock is low.

Towards the controller the block gives a one-cycle valid strobe with each received byte and a flag that marks the address byte. It also gives one-cycle strobes for the opening and closing conditions and a request strobe each time it takes a byte to transmit. A standby flag is raised at reset. It is raised again when a frame closes without having started a write, and when the controller reports that an internal write has finished. Any movement on either bus line clears it.

Top module: `twi_slave_front`

## Requirements
- R1: After reset, and after a closing condition or an address mismatch, clock pulses and data changes are ignored until an opening condition: no acknowledge, no received-byte strobe and no transmit request.
- R2: A falling data line while the clock line is high gives one `start_o` strobe. It aborts any transfer in progress and restarts bit counting with the next bit taken as the first bit of an address byte.
- R3: A rising data line while the clock line is high gives one `stop_o` strobe, releases the data line and returns the block to the ignoring state of R1.
- R4: Bits are sampled on clock-line rising edges and assembled most significant bit first. After the eighth bit, `rx_valid_o` pulses for one cycle with the byte on `rx_byte_o`. `rx_is_addr_o` is 1 for the address byte and 0 for data bytes.
- R5: An address byte whose bits 7..1 equal parameter `DEV_ADDR` is acknowledged by pulling the data line low for the whole ninth clock pulse. Bit 0 of that byte selects the direction, with 1 meaning read.
- R6: An address byte that does not match gives no acknowledge and no `rx_valid_o`. The block then ignores the bus until the next opening condition.
- R7: In a write frame, every data byte is acknowledged on its ninth clock pulse and reported through `rx_valid_o`.
- R8: In a read frame, the block samples `tx_byte_i` and pulses `tx_req_o` at the clock-line falling edge that ends the address acknowledge, and shifts that byte out most significant bit first. After eight bits it releases the line. A master acknowledge (line low on the ninth pulse) loads and sends the next byte. A master non-acknowledge ends the transfer.
- R9: The data-line drive `sda_pull_o` changes only in cycles that follow a synchronised clock-line low level.
- R10: `standby_o` is 1 after reset. Any level change on either synchronised bus line clears it.
- R11: A closing condition sets `standby_o` when the frame received no write data byte. After a frame that did write, `standby_o` stays 0 until a `wr_done_i` pulse sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired value) |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| tx_byte_i | input | 8 | Byte to send in a read frame, sampled at each `tx_req_o` |
| tx_req_o | output | 1 | One-cycle strobe: `tx_byte_i` taken |
| rx_valid_o | output | 1 | One-cycle strobe: a received byte is on `rx_byte_o` |
| rx_byte_o | output | 8 | Last received byte |
| rx_is_addr_o | output | 1 | Byte on `rx_byte_o` is the address byte |
| start_o | output | 1 | One-cycle strobe on an opening condition |
| stop_o | output | 1 | One-cycle strobe on a closing condition |
| wr_done_i | input | 1 | One-cycle strobe: internal write finished |
| standby_o | output | 1 | Standby indication |

## Verification
The bench builds the block with `DEV_ADDR` = 7'h50 and `SYNC_STAGES` = 2. This makes 8'hA0 a write address, 8'hA1 a read address and 8'hA2 a near-miss that differs only in the lowest address bit. Each bus quarter-period lasts five system clocks, which is longer than the synchroniser and edge-detect latency. Acknowledges can therefore be read from the wired line in the middle of each high phase. The table covers matched and mismatched frames with data patterns that catch bit-order faults. Directed cases cover the power-up standby flag, activity before any opening condition, a two-byte read ended by a non-acknowledge, and an opening condition after three address bits.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam int BYTE_BITS = 8;

    // synchronised line view and framing events, one system-clock cycle each
    typedef struct packed {
        logic scl_hi;
        logic sda_hi;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_RECV,
        PH_ACK,
        PH_SEND,
        PH_MACK
    } phase_e;

    function automatic logic addr_hit(input logic [BYTE_BITS-1:0] b,
                                      input logic [BYTE_BITS-2:0] dev);
        return b[BYTE_BITS-1:1] == dev;
    endfunction

endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_s,
    output logic line_q
);
    generate
        if (STAGES <= 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) line_s <= 1'b1;
                else     line_s <= line_i;
            end
        end else begin : g_chain
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '1;
                else     chain <= {chain[STAGES-2:0], line_i};
            end
            assign line_s = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) line_q <= 1'b1;
        else     line_q <= line_s;
    end
endmodule

// File: rtl/twi_bus_events.sv
module twi_bus_events
    import twi_pkg::*;
(
    input  logic    scl_s,
    input  logic    scl_q,
    input  logic    sda_s,
    input  logic    sda_q,
    output bus_ev_t ev,
    output logic    toggle
);
    always_comb begin
        ev.scl_hi   = scl_s;
        ev.sda_hi   = sda_s;
        ev.scl_rise = scl_s & ~scl_q;
        ev.scl_fall = ~scl_s & scl_q;
        ev.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev.stop     = scl_s & scl_q & ~sda_q & sda_s;
        toggle      = (scl_s ^ scl_q) | (sda_s ^ sda_q);
    end
endmodule

// File: rtl/twi_bit_engine.sv
module twi_bit_engine
    import twi_pkg::*;
#(
    parameter logic [BYTE_BITS-2:0] DEV_ADDR = 7'h50
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_ev_t              ev,
    input  logic [BYTE_BITS-1:0] tx_byte,
    output logic                 sda_pull,
    output logic                 tx_req,
    output logic                 rx_valid,
    output logic [BYTE_BITS-1:0] rx_byte,
    output logic                 rx_is_addr,
    output logic                 wr_seen
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_BITS - 1);
    localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(BYTE_BITS);

    phase_e               phase;
    logic [CNT_W-1:0]     cnt;
    logic [BYTE_BITS-1:0] shreg;
    logic                 addr_phase;
    logic                 rd_dir;
    logic                 ack_ok;
    logic                 mack_ok;
    logic [BYTE_BITS-1:0] next_byte;

    always_comb next_byte = {shreg[BYTE_BITS-2:0], ev.sda_hi};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            cnt        <= '0;
            shreg      <= '0;
            addr_phase <= 1'b0;
            rd_dir     <= 1'b0;
            ack_ok     <= 1'b0;
            mack_ok    <= 1'b0;
            sda_pull   <= 1'b0;
            tx_req     <= 1'b0;
            rx_valid   <= 1'b0;
            rx_byte    <= '0;
            rx_is_addr <= 1'b0;
            wr_seen    <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            tx_req   <= 1'b0;
            if (ev.start) begin
                phase      <= PH_RECV;
                cnt        <= '0;
                addr_phase <= 1'b1;
                rd_dir     <= 1'b0;
                ack_ok     <= 1'b0;
                sda_pull   <= 1'b0;
                wr_seen    <= 1'b0;
            end else if (ev.stop) begin
                phase    <= PH_IDLE;
                cnt      <= '0;
                sda_pull <= 1'b0;
                wr_seen  <= 1'b0;
            end else begin
                unique case (phase)
                    PH_RECV: begin
                        if (ev.scl_rise && cnt != FULL_BYTE) begin
                            shreg <= next_byte;
                            cnt   <= cnt + 1'b1;
                            if (cnt == LAST_BIT) begin
                                if (addr_phase) begin
                                    if (addr_hit(next_byte, DEV_ADDR)) begin
                                        ack_ok     <= 1'b1;
                                        rd_dir     <= next_byte[0];
                                        rx_valid   <= 1'b1;
                                        rx_byte    <= next_byte;
                                        rx_is_addr <= 1'b1;
                                    end else begin
                                        ack_ok <= 1'b0;
                                    end
                                end else begin
                                    ack_ok     <= 1'b1;
                                    rx_valid   <= 1'b1;
                                    rx_byte    <= next_byte;
                                    rx_is_addr <= 1'b0;
                                    wr_seen    <= 1'b1;
                                end
                            end
                        end else if (ev.scl_fall && cnt == FULL_BYTE) begin
                            cnt <= '0;
                            if (ack_ok) begin
                                sda_pull <= 1'b1;
                                phase    <= PH_ACK;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    PH_ACK: begin
                        if (ev.scl_fall) begin
                            addr_phase <= 1'b0;
                            if (rd_dir) begin
                                shreg    <= tx_byte;
                                sda_pull <= ~tx_byte[BYTE_BITS-1];
                                tx_req   <= 1'b1;
                                phase    <= PH_SEND;
                            end else begin
                                sda_pull <= 1'b0;
                                phase    <= PH_RECV;
                            end
                        end
                    end
                    PH_SEND: begin
                        if (ev.scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall) begin
                            if (cnt == FULL_BYTE) begin
                                sda_pull <= 1'b0;
                                cnt      <= '0;
                                phase    <= PH_MACK;
                            end else begin
                                sda_pull <= ~shreg[BYTE_BITS-2];
                                shreg    <= {shreg[BYTE_BITS-2:0], shreg[BYTE_BITS-1]};
                            end
                        end
                    end
                    PH_MACK: begin
                        if (ev.scl_rise) begin
                            mack_ok <= ~ev.sda_hi;
                        end else if (ev.scl_fall) begin
                            if (mack_ok) begin
                                shreg    <= tx_byte;
                                sda_pull <= ~tx_byte[BYTE_BITS-1];
                                tx_req   <= 1'b1;
                                phase    <= PH_SEND;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    start_resync_chk: assert property (@(posedge clk) disable iff (rst)
        ev.start |=> (phase == PH_RECV && cnt == '0 && addr_phase && !sda_pull));

    // R3
    stop_release_chk: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> (phase == PH_IDLE && !sda_pull));

    // R9
    drive_low_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sda_pull) && !$past(ev.start || ev.stop)) |-> !$past(ev.scl_hi));

    // R6
    mismatch_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && rx_is_addr) |-> addr_hit(rx_byte, DEV_ADDR));
endmodule

// File: rtl/twi_standby.sv
module twi_standby (
    input  logic clk,
    input  logic rst,
    input  logic toggle,
    input  logic stop,
    input  logic wr_seen,
    input  logic wr_done,
    output logic standby
);
    always_ff @(posedge clk) begin
        if (rst)                              standby <= 1'b1;
        else if ((stop && !wr_seen) || wr_done) standby <= 1'b1;
        else if (toggle)                      standby <= 1'b0;
    end

    // R10
    standby_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> standby);

    // R11
    write_done_standby_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_done) |-> standby);
endmodule

// File: rtl/twi_slave_front.sv
module twi_slave_front
    import twi_pkg::*;
#(
    parameter logic [BYTE_BITS-2:0] DEV_ADDR    = 7'h50,
    parameter int                   SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_pull_o,
    input  logic [BYTE_BITS-1:0] tx_byte_i,
    output logic                 tx_req_o,
    output logic                 rx_valid_o,
    output logic [BYTE_BITS-1:0] rx_byte_o,
    output logic                 rx_is_addr_o,
    output logic                 start_o,
    output logic                 stop_o,
    input  logic                 wr_done_i,
    output logic                 standby_o
);
    logic    scl_s, scl_q, sda_s, sda_q;
    bus_ev_t ev;
    logic    toggle;
    logic    wr_seen;

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
        .clk(clk), .rst(rst), .line_i(scl_i), .line_s(scl_s), .line_q(scl_q));

    twi_line_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
        .clk(clk), .rst(rst), .line_i(sda_i), .line_s(sda_s), .line_q(sda_q));

    twi_bus_events u_events (
        .scl_s(scl_s), .scl_q(scl_q), .sda_s(sda_s), .sda_q(sda_q),
        .ev(ev), .toggle(toggle));

    twi_bit_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk(clk), .rst(rst), .ev(ev), .tx_byte(tx_byte_i),
        .sda_pull(sda_pull_o), .tx_req(tx_req_o), .rx_valid(rx_valid_o),
        .rx_byte(rx_byte_o), .rx_is_addr(rx_is_addr_o), .wr_seen(wr_seen));

    twi_standby u_standby (
        .clk(clk), .rst(rst), .toggle(toggle), .stop(ev.stop),
        .wr_seen(wr_seen), .wr_done(wr_done_i), .standby(standby_o));

    assign start_o = ev.start;
    assign stop_o  = ev.stop;
endmodule

// File: tb/sim_twi_slave_front.sv
module sim_twi_slave_front;
    localparam int Q = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_pull;
    logic       sda_line;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_req, rx_valid, rx_is_addr, start_s, stop_s, standby;
    logic [7:0] rx_byte;
    logic       wr_done = 1'b0;

    int total = 0;
    int bad = 0;
    int n_rx = 0, n_start = 0, n_stop = 0, n_txreq = 0;
    logic [7:0] got_addr = 8'h00, got_data = 8'h00;
    logic done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    twi_slave_front #(.DEV_ADDR(7'h50), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line),
        .sda_pull_o(sda_pull), .tx_byte_i(tx_byte), .tx_req_o(tx_req),
        .rx_valid_o(rx_valid), .rx_byte_o(rx_byte), .rx_is_addr_o(rx_is_addr),
        .start_o(start_s), .stop_o(stop_s), .wr_done_i(wr_done),
        .standby_o(standby));

    always @(negedge clk) begin
        if (!rst) begin
            if (rx_valid) begin
                n_rx++;
                if (rx_is_addr) got_addr = rx_byte;
                else            got_data = rx_byte;
            end
            if (start_s) n_start++;
            if (stop_s)  n_stop++;
            if (tx_req)  n_txreq++;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_counts();
        n_rx = 0; n_start = 0; n_stop = 0; n_txreq = 0;
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        @(negedge clk); scl_m = 1'b0;
        wait_clk(Q); sda_m = b;
        wait_clk(Q); scl_m = 1'b1;
        wait_clk(Q); seen = sda_line;
        wait_clk(Q); scl_m = 1'b0;
    endtask

    task automatic bus_start();
        @(negedge clk); sda_m = 1'b1;
        wait_clk(Q); scl_m = 1'b1;
        wait_clk(2*Q); sda_m = 1'b0;
        wait_clk(2*Q); scl_m = 1'b0;
        wait_clk(Q);
    endtask

    task automatic bus_stop();
        @(negedge clk); scl_m = 1'b0;
        wait_clk(Q); sda_m = 1'b0;
        wait_clk(Q); scl_m = 1'b1;
        wait_clk(2*Q); sda_m = 1'b1;
        wait_clk(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
        bus_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic read_bits(output logic [7:0] b);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            b[i] = s;
        end
    endtask

    task automatic pulse_wr_done();
        @(negedge clk); wr_done = 1'b1;
        @(negedge clk); wr_done = 1'b0;
        wait_clk(2);
    endtask

    // {address byte, data byte, address expected to match}
    localparam logic [16:0] VEC [4] = '{
        {8'hA0, 8'h3C, 1'b1},
        {8'hA0, 8'hC5, 1'b1},
        {8'hA2, 8'h55, 1'b0},
        {8'hA0, 8'h01, 1'b1}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic a1, a2;
        logic [7:0] rd;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);

        // R10: power-up state
        check("R10 standby after reset", 32'(standby), 32'd1);
        check("R3 line released after reset", 32'(sda_pull), 32'd0);

        // R1: a matching address clocked in without any opening condition
        clear_counts();
        send_byte(8'hA0, a1);
        check("R1 no ack before start", 32'(a1), 32'd0);
        check("R1 no byte before start", 32'(n_rx), 32'd0);
        check("R1 no start seen", 32'(n_start), 32'd0);
        wait_clk(3);
        check("R10 standby cleared by line activity", 32'(standby), 32'd0);

        // table of write frames
        for (int k = 0; k < 4; k++) begin
            logic [7:0] va, vd;
            logic ve;
            {va, vd, ve} = VEC[k];
            clear_counts();
            bus_start();
            check("R2 start strobe", 32'(n_start), 32'd1);
            send_byte(va, a1);
            check(ve ? "R5 address ack" : "R6 mismatch no ack", 32'(a1), 32'(ve));
            send_byte(vd, a2);
            check(ve ? "R7 data ack" : "R6 data ignored", 32'(a2), 32'(ve));
            check("R4 byte count", 32'(n_rx), ve ? 32'd2 : 32'd0);
            if (ve) begin
                check("R4 address byte", 32'(got_addr), 32'(va));
                check("R4 data byte msb first", 32'(got_data), 32'(vd));
            end
            bus_stop();
            check("R3 stop strobe", 32'(n_stop), 32'd1);
            check("R3 released after stop", 32'(sda_pull), 32'd0);
            check("R11 standby after stop", 32'(standby), 32'(!ve));
            if (ve) begin
                pulse_wr_done();
                check("R11 standby after write done", 32'(standby), 32'd1);
            end
        end

        // R8: two-byte read, master acks first, nacks second
        clear_counts();
        tx_byte = 8'h96;
        bus_start();
        send_byte(8'hA1, a1);
        check("R5 read address ack", 32'(a1), 32'd1);
        read_bits(rd);
        check("R8 first read byte", 32'(rd), 32'h96);
        tx_byte = 8'h3B;
        bus_bit(1'b0, a2);
        read_bits(rd);
        check("R8 second read byte", 32'(rd), 32'h3B);
        bus_bit(1'b1, a2);
        check("R8 transmit requests", 32'(n_txreq), 32'd2);
        bus_stop();
        check("R3 stop after read", 32'(n_stop), 32'd1);
        check("R11 standby after read frame", 32'(standby), 32'd1);

        // R2: opening condition after three address bits
        clear_counts();
        bus_start();
        bus_bit(1'b1, a1);
        bus_bit(1'b0, a1);
        bus_bit(1'b1, a1);
        bus_start();
        check("R2 repeated start strobes", 32'(n_start), 32'd2);
        send_byte(8'hA0, a1);
        check("R2 address after resync acked", 32'(a1), 32'd1);
        send_byte(8'h77, a2);
        check("R7 data after resync acked", 32'(a2), 32'd1);
        check("R2 bytes after resync", 32'(n_rx), 32'd2);
        check("R4 data after resync", 32'(got_data), 32'h77);
        bus_stop();
        check("R11 standby held after write", 32'(standby), 32'd0);
        pulse_wr_done();
        check("R11 standby set by write done", 32'(standby), 32'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule